// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which of seven clocking modes a clock generator runs in. Software-visible control bits reach it as plain inputs: a reference-select bit, a two-bit clock-select field, a low-power bit and a fine-trim bit. It also takes a debug-active flag, a stop request, an external-reference enable and an oscillator-select bit. Each cycle it works out the mode the controls ask for and registers it. From that registered mode it drives an enable for the frequency-locked loop, a select code for the output clock mux, and a one-hot copy of the mode.

A stop request parks the controller in a dedicated halt mode and remembers the mode it came from. Releasing the request restores that mode. A reset taken while halted discards the saved mode, so the controller comes back in the default mode. A start-up counter tracks the external oscillator and raises a ready flag once the oscillator has been requested for the configured number of cycles. The fine-trim bit is registered and passed on to the analog trim circuit. The loop, the oscillator and the trim circuit are outside this block.

Top module: `clk_mode_ctrl`

## Requirements
- R1: With clock-select 00, a reference-select of 1 gives the loop-on-internal mode (code 0) and a reference-select of 0 gives the loop-on-external mode (code 1). The change appears one clock after the inputs are sampled.
- R2: Reference-select 1 with clock-select 01 gives internal bypass (code 2). Reference-select 0 with clock-select 10 gives external bypass (code 4).
- R3: A bypass mode turns into its low-power variant (internal code 3, external code 5) only while low_pwr is 1 and dbg_active is 0. Otherwise the normal bypass code is used, and the mode re-evaluates every cycle.
- R4: Clock-select 11 leaves the mode unchanged. So do the mismatched pairs (reference-select 0 with 01, reference-select 1 with 10).
- R5: A synchronous reset sets mode 0, the loop enable to 1, mux select 00, the ready flag to 0, the start-up count to 0 and trim_out to 0.
- R6: A stop request sampled at a clock edge puts the controller in the halt mode (code 6) at that edge. It stays there while the request holds, whatever the other controls do.
- R7: When the request is released, the controller returns at the next edge to the mode it held before halt. After a reset taken during halt, it returns to code 0.
- R8: fll_en is 1 in codes 0, 1, 2 and 4, and 0 in codes 3, 5 and 6. clk_mux_sel is 00 (loop output) for codes 0 and 1, 01 (internal reference) for codes 2 and 3, 10 (external reference) for codes 4 and 5, and 11 (no clock) for code 6.
- R9: The oscillator is requested when osc_sel is 1 and either xref_en is 1 or the current mode is 1, 4 or 5. While requested, osc_count climbs by one per cycle and saturates at STARTUP_CYCLES. osc_ready rises at the edge where the count reaches that value. A cycle without the request returns the count to 0.
- R10: osc_ready falls only at an edge where xref_en or osc_sel has just gone from 1 to 0. Leaving an external mode while xref_en is already 0 does not clear it.
- R11: trim_out is the value of trim_fine sampled at the previous clock edge. A 1 lengthens the internal reference period by one step and a 0 shortens it by one step.
- R12: Bit k of mode_onehot is 1 exactly when mode_code equals k, for k from 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_int | input | 1 | Reference select: 1 internal, 0 external |
| clk_sel | input | 2 | Clock-select field |
| low_pwr | input | 1 | Low-power request for bypass modes |
| dbg_active | input | 1 | Debug session active |
| stop_req | input | 1 | Stop request |
| xref_en | input | 1 | External reference enable |
| osc_sel | input | 1 | Oscillator (rather than plain clock input) select |
| trim_fine | input | 1 | Fine-trim bit |
| mode_code | output | 3 | Registered mode code |
| mode_onehot | output | 7 | One-hot copy of the mode code |
| fll_en | output | 1 | Frequency-locked loop enable |
| clk_mux_sel | output | 2 | Output clock mux select |
| osc_ready | output | 1 | Oscillator start-up complete |
| osc_count | output | $clog2(STARTUP_CYCLES+1) | Start-up cycle count |
| trim_out | output | 1 | Registered fine-trim value |

## Verification
The mode decode is exercised with every reference/clock-select pairing, including the reserved and mismatched ones. This separates a real mode change from a hold. The low-power and debug bits are toggled while the controller sits in each bypass mode, so a wrong priority between them shows up as a wrong code or a wrong loop enable. Stop is applied from a low-power mode, and the controls are changed while halted. This shows that the saved mode, not the current decode, is restored. A reset inside halt shows that the saved mode is discarded. Start-up is tested with an uninterrupted request, with a request broken after a few cycles (which must restart the count), and with each of the two ways the request can be withdrawn. These cases tell the clearing causes of the ready flag apart.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  typedef enum logic [2:0] {
    MD_LOOP_INT   = 3'd0,
    MD_LOOP_EXT   = 3'd1,
    MD_BYP_INT    = 3'd2,
    MD_BYP_INT_LP = 3'd3,
    MD_BYP_EXT    = 3'd4,
    MD_BYP_EXT_LP = 3'd5,
    MD_HALT       = 3'd6
  } mode_t;

  localparam int unsigned NUM_MODES = 7;

  localparam logic [1:0] MUX_LOOP = 2'b00;
  localparam logic [1:0] MUX_IREF = 2'b01;
  localparam logic [1:0] MUX_XREF = 2'b10;
  localparam logic [1:0] MUX_NONE = 2'b11;

  function automatic logic loop_on(input mode_t m);
    case (m)
      MD_LOOP_INT, MD_LOOP_EXT, MD_BYP_INT, MD_BYP_EXT: loop_on = 1'b1;
      default:                                          loop_on = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] mux_code(input mode_t m);
    case (m)
      MD_LOOP_INT, MD_LOOP_EXT:     mux_code = MUX_LOOP;
      MD_BYP_INT, MD_BYP_INT_LP:    mux_code = MUX_IREF;
      MD_BYP_EXT, MD_BYP_EXT_LP:    mux_code = MUX_XREF;
      default:                      mux_code = MUX_NONE;
    endcase
  endfunction

  function automatic logic uses_xref(input mode_t m);
    case (m)
      MD_LOOP_EXT, MD_BYP_EXT, MD_BYP_EXT_LP: uses_xref = 1'b1;
      default:                                uses_xref = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import clk_mode_pkg::*;
(
  input  logic       ref_int,
  input  logic [1:0] clk_sel,
  input  logic       low_pwr,
  input  logic       dbg_active,
  input  mode_t      cur_mode,
  output mode_t      tgt_mode
);

  logic lp_ok;
  assign lp_ok = low_pwr & ~dbg_active;

  always_comb begin
    tgt_mode = cur_mode;
    unique case ({ref_int, clk_sel})
      3'b1_00: tgt_mode = MD_LOOP_INT;
      3'b0_00: tgt_mode = MD_LOOP_EXT;
      3'b1_01: tgt_mode = lp_ok ? MD_BYP_INT_LP : MD_BYP_INT;
      3'b0_10: tgt_mode = lp_ok ? MD_BYP_EXT_LP : MD_BYP_EXT;
      default: tgt_mode = cur_mode;
    endcase
  end

endmodule

// File: rtl/mode_seq.sv
module mode_seq
  import clk_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_req,
  input  logic [1:0]           clk_sel,
  input  mode_t                tgt_mode,
  output mode_t                mode_q,
  output logic [NUM_MODES-1:0] onehot_q,
  output logic                 fll_q,
  output logic [1:0]           mux_q
);

  mode_t saved_q;
  mode_t mode_d;
  mode_t saved_d;

  always_comb begin
    mode_d  = mode_q;
    saved_d = saved_q;
    if (stop_req) begin
      if (mode_q != MD_HALT) saved_d = mode_q;
      mode_d = MD_HALT;
    end else if (mode_q == MD_HALT) begin
      mode_d = saved_q;
    end else begin
      mode_d = tgt_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_LOOP_INT;
      saved_q <= MD_LOOP_INT;
      fll_q   <= 1'b1;
      mux_q   <= MUX_LOOP;
    end else begin
      mode_q  <= mode_d;
      saved_q <= saved_d;
      fll_q   <= loop_on(mode_d);
      mux_q   <= mux_code(mode_d);
    end
  end

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_onehot
    always_ff @(posedge clk) begin
      if (rst) onehot_q[g] <= (g == 0);
      else     onehot_q[g] <= (mode_d == mode_t'(g));
    end
  end

  AST_STOP_ENTER: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (mode_q == MD_HALT)); // R6
  AST_STOP_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HALT && !stop_req) |=> (mode_q == $past(saved_q))); // R7
  AST_LOWPWR_LOOP_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_BYP_INT_LP || mode_q == MD_BYP_EXT_LP || mode_q == MD_HALT) |-> !fll_q); // R8
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stop_req && mode_q != MD_HALT && clk_sel == 2'b11) |=> $stable(mode_q)); // R4
  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (rst)
    onehot_q[mode_q] && ($countones(onehot_q) == 1)); // R12

endmodule

// File: rtl/osc_startup.sv
module osc_startup #(
  parameter int unsigned STARTUP_CYCLES = 4096,
  localparam int unsigned CNT_W = $clog2(STARTUP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_sel,
  input  logic             xref_en,
  input  logic             ext_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ready_q
);

  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(STARTUP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYCLES - 1);

  logic req;
  logic en_prev_q;
  logic sel_prev_q;
  logic drop_evt;

  assign req      = osc_sel & (xref_en | ext_mode);
  assign drop_evt = (en_prev_q & ~xref_en) | (sel_prev_q & ~osc_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      ready_q    <= 1'b0;
      en_prev_q  <= 1'b0;
      sel_prev_q <= 1'b0;
    end else begin
      en_prev_q  <= xref_en;
      sel_prev_q <= osc_sel;
      if (!req)                cnt_q <= '0;
      else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      if (drop_evt)                         ready_q <= 1'b0;
      else if (req && cnt_q == CNT_LAST)    ready_q <= 1'b1;
    end
  end

  AST_READY_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> (cnt_q == CNT_TOP)); // R9
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    !req |=> (cnt_q == '0)); // R9
  AST_READY_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($past(ready_q) && !ready_q) |->
      (($past(en_prev_q) && !$past(xref_en)) || ($past(sel_prev_q) && !$past(osc_sel)))); // R10

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 4096,
  localparam int unsigned CNT_W = $clog2(STARTUP_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_int,
  input  logic [1:0]           clk_sel,
  input  logic                 low_pwr,
  input  logic                 dbg_active,
  input  logic                 stop_req,
  input  logic                 xref_en,
  input  logic                 osc_sel,
  input  logic                 trim_fine,
  output logic [2:0]           mode_code,
  output logic [NUM_MODES-1:0] mode_onehot,
  output logic                 fll_en,
  output logic [1:0]           clk_mux_sel,
  output logic                 osc_ready,
  output logic [CNT_W-1:0]     osc_count,
  output logic                 trim_out
);

  mode_t cur_mode;
  mode_t tgt_mode;
  logic  trim_q;

  mode_decode u_decode (
    .ref_int    (ref_int),
    .clk_sel    (clk_sel),
    .low_pwr    (low_pwr),
    .dbg_active (dbg_active),
    .cur_mode   (cur_mode),
    .tgt_mode   (tgt_mode)
  );

  mode_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .clk_sel  (clk_sel),
    .tgt_mode (tgt_mode),
    .mode_q   (cur_mode),
    .onehot_q (mode_onehot),
    .fll_q    (fll_en),
    .mux_q    (clk_mux_sel)
  );

  osc_startup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_osc (
    .clk      (clk),
    .rst      (rst),
    .osc_sel  (osc_sel),
    .xref_en  (xref_en),
    .ext_mode (uses_xref(cur_mode)),
    .cnt_q    (osc_count),
    .ready_q  (osc_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) trim_q <= 1'b0;
    else     trim_q <= trim_fine;
  end

  assign mode_code = cur_mode;
  assign trim_out  = trim_q;

  AST_RESET_DEFAULT: assert property (@(posedge clk)
    $past(rst) |-> (mode_code == 3'd0 && !osc_ready && !trim_out)); // R5
  AST_TRIM_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (trim_out == $past(trim_fine))); // R11

endmodule

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ST = 8;
  localparam int CW = $clog2(ST + 1);

  logic clk = 1'b0;
  logic rst, ref_int, low_pwr, dbg_active, stop_req, xref_en, osc_sel, trim_fine;
  logic [1:0] clk_sel;
  logic [2:0] mode_code;
  logic [6:0] mode_onehot;
  logic fll_en, osc_ready, trim_out;
  logic [1:0] clk_mux_sel;
  logic [CW-1:0] osc_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl #(.STARTUP_CYCLES(ST)) dut_i (
    .clk(clk), .rst(rst), .ref_int(ref_int), .clk_sel(clk_sel), .low_pwr(low_pwr),
    .dbg_active(dbg_active), .stop_req(stop_req), .xref_en(xref_en), .osc_sel(osc_sel),
    .trim_fine(trim_fine), .mode_code(mode_code), .mode_onehot(mode_onehot),
    .fll_en(fll_en), .clk_mux_sel(clk_mux_sel), .osc_ready(osc_ready),
    .osc_count(osc_count), .trim_out(trim_out)
  );

  // behavioural reference model
  int m_mode, m_saved, m_cnt;
  bit m_ready, m_pe, m_ps, m_trim, live;

  function automatic int target(int cur);
    if (clk_sel == 2'b00) return ref_int ? 0 : 1;
    if (clk_sel == 2'b01 && ref_int)  return (low_pwr && !dbg_active) ? 3 : 2;
    if (clk_sel == 2'b10 && !ref_int) return (low_pwr && !dbg_active) ? 5 : 4;
    return cur;
  endfunction

  function automatic bit exp_fll(int m);
    return (m == 0 || m == 1 || m == 2 || m == 4);
  endfunction

  function automatic int exp_mux(int m);
    if (m <= 1) return 0;
    if (m <= 3) return 1;
    if (m <= 5) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_saved = 0; m_cnt = 0; m_ready = 0; m_pe = 0; m_ps = 0; m_trim = 0;
      live = 1;
    end else if (live) begin
      bit req, drop;
      req  = osc_sel && (xref_en || m_mode == 1 || m_mode == 4 || m_mode == 5);
      drop = (m_pe && !xref_en) || (m_ps && !osc_sel);
      if (drop) m_ready = 0;
      else if (req && m_cnt == ST - 1) m_ready = 1;
      if (!req) m_cnt = 0;
      else if (m_cnt < ST) m_cnt++;
      m_pe = xref_en; m_ps = osc_sel; m_trim = trim_fine;
      if (stop_req) begin
        if (m_mode != 6) m_saved = m_mode;
        m_mode = 6;
      end else if (m_mode == 6) m_mode = m_saved;
      else m_mode = target(m_mode);
    end
  end

  task automatic cmp(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      cmp(int'(mode_code), m_mode, "R1 R2 R3 R4 R6 R7 mode_code");
      cmp(int'(mode_onehot), 1 << m_mode, "R12 mode_onehot");
      cmp(int'(fll_en), int'(exp_fll(m_mode)), "R8 fll_en");
      cmp(int'(clk_mux_sel), exp_mux(m_mode), "R8 clk_mux_sel");
      cmp(int'(osc_ready), int'(m_ready), "R9 R10 osc_ready");
      cmp(int'(osc_count), m_cnt, "R9 osc_count");
      cmp(int'(trim_out), int'(m_trim), "R11 trim_out");
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_mode_in(input bit r, input logic [1:0] s, input bit lp, input bit dbg);
    ref_int = r; clk_sel = s; low_pwr = lp; dbg_active = dbg;
  endtask

  initial begin
    rst = 1; stop_req = 0; xref_en = 0; osc_sel = 0; trim_fine = 0;
    set_mode_in(1, 2'b00, 0, 0);
    cyc(2);
    rst = 0;
    cmp(int'(mode_code), 0, "R5 reset mode");
    cmp(int'(fll_en), 1, "R5 reset fll_en");
    cmp(int'(clk_mux_sel), 0, "R5 reset mux");
    cmp(int'(osc_ready), 0, "R5 reset ready");
    // R1
    set_mode_in(0, 2'b00, 0, 0); cyc();
    cmp(int'(mode_code), 1, "R1 loop external");
    set_mode_in(1, 2'b00, 0, 0); cyc();
    cmp(int'(mode_code), 0, "R1 loop internal");
    // R2, R3
    set_mode_in(1, 2'b01, 0, 0); cyc();
    cmp(int'(mode_code), 2, "R2 internal bypass");
    low_pwr = 1; cyc();
    cmp(int'(mode_code), 3, "R3 internal bypass low power");
    cmp(int'(fll_en), 0, "R8 loop off in low power");
    dbg_active = 1; cyc();
    cmp(int'(mode_code), 2, "R3 debug blocks low power");
    set_mode_in(0, 2'b10, 1, 0); cyc();
    cmp(int'(mode_code), 5, "R3 external bypass low power");
    cmp(int'(clk_mux_sel), 2, "R8 external mux");
    low_pwr = 0; cyc();
    cmp(int'(mode_code), 4, "R2 external bypass");
    // R4
    clk_sel = 2'b11; cyc();
    cmp(int'(mode_code), 4, "R4 reserved select holds");
    set_mode_in(1, 2'b10, 0, 0); cyc();
    cmp(int'(mode_code), 4, "R4 mismatched pair holds");
    // R9: request through external mode
    set_mode_in(0, 2'b10, 0, 0); osc_sel = 1; cyc(ST - 1);
    cmp(int'(osc_ready), 0, "R9 not ready before count");
    cyc();
    cmp(int'(osc_ready), 1, "R9 ready after count");
    // R10: leaving external mode with xref_en low keeps ready
    set_mode_in(1, 2'b00, 0, 0); cyc(3);
    cmp(int'(osc_ready), 1, "R10 ready kept on mode change");
    xref_en = 1; cyc();
    xref_en = 0; cyc();
    cmp(int'(osc_ready), 0, "R10 cleared by enable drop");
    // R9: broken request restarts count
    xref_en = 1; cyc(4);
    xref_en = 0; cyc();
    xref_en = 1; cyc(ST - 1);
    cmp(int'(osc_ready), 0, "R9 count restarted");
    cyc();
    cmp(int'(osc_ready), 1, "R9 ready after restart");
    osc_sel = 0; cyc();
    cmp(int'(osc_ready), 0, "R10 cleared by select drop");
    xref_en = 0;
    // R11
    trim_fine = 1; cyc();
    cmp(int'(trim_out), 1, "R11 trim set");
    trim_fine = 0; cyc();
    cmp(int'(trim_out), 0, "R11 trim clear");
    // R6, R7
    set_mode_in(1, 2'b01, 1, 0); cyc();
    cmp(int'(mode_code), 3, "R3 before stop");
    stop_req = 1; cyc();
    cmp(int'(mode_code), 6, "R6 halt entered");
    cmp(int'(clk_mux_sel), 3, "R8 halt mux");
    set_mode_in(0, 2'b00, 0, 0); cyc(2);
    cmp(int'(mode_code), 6, "R6 halt ignores controls");
    stop_req = 0; cyc();
    cmp(int'(mode_code), 3, "R7 saved mode restored");
    cyc();
    cmp(int'(mode_code), 1, "R1 decode resumes after halt");
    // reset during halt
    set_mode_in(1, 2'b01, 0, 0); cyc();
    stop_req = 1; cyc();
    cmp(int'(mode_code), 6, "R6 halt again");
    rst = 1; cyc();
    rst = 0; clk_sel = 2'b11; cyc();
    cmp(int'(mode_code), 6, "R6 halt after reset");
    stop_req = 0; cyc();
    cmp(int'(mode_code), 0, "R7 default after reset in halt");
    cmp(int'(mode_onehot), 1, "R12 onehot default");
    cyc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule